// File: doc/BRIEF.md
# Machine Cycle Timing Sequencer

This block paces the bus activity of a small 8-bit processor core whose 16-bit memory address leaves the chip on one set of eight pins. Each machine cycle is cut into a fixed number of clock phases. From the phase count and the cycle type, the block produces two single-clock timing pulses, a select that sends the upper address byte to the pins before the lower byte, and active-low read and write strobes.

The sequencer chooses the type of each machine cycle: instruction fetch, execute, direct memory transfer or interrupt entry. It reports that choice on a two-bit code. Pending transfer and interrupt requests are sampled at the timing pulse late in execute and transfer cycles, and the four external flag lines are captured during execute cycles. The decode logic gives three inputs: a read request, a write request and a marker for a long instruction. A long instruction takes a second execute cycle. A synchronous clear restarts the sequence, and a wait input freezes it.

Top module: `mc_seq`

## Requirements
- R1: `phase_o` counts 0,1,...,7 and then wraps to 0, moving one step per clock while neither wait nor clear is active.
- R2: `tpa_o` is high only in phase 1 and `tpb_o` only in phase 6, each for one clock per machine cycle.
- R3: `addr_hi_o` is 1 (upper address byte on the pins) in phases 0 and 1 and is 0 (lower byte) in phases 2 to 7.
- R4: `rd_n_o` is low in phases 2 to 7 of every fetch cycle, and of every execute or transfer cycle whose `rd_req_i` is 1 and `wr_req_i` is 0 at the end of phase 0. It is high at all other times, and always high in interrupt cycles.
- R5: `wr_n_o` is low only in phases 4 and 5 of an execute or transfer cycle whose `wr_req_i` is 1 at the end of phase 0. It is never low in fetch or interrupt cycles.
- R6: `state_code_o` is 00 for fetch, 01 for execute, 10 for transfer and 11 for interrupt. It changes only when phase 0 begins. A fetch is always followed by an execute, and an interrupt cycle by a fetch.
- R7: If `long_i` is 1 at the end of the first execute cycle, a second execute cycle follows. No instruction gets a third execute cycle.
- R8: `dma_req_i` and `int_req_i` are sampled at the end of phase 6 of execute and transfer cycles only. After the last execute cycle or a transfer cycle, the next cycle is a transfer cycle if a transfer was sampled, otherwise an interrupt cycle if an interrupt was sampled, otherwise a fetch. Requests present during fetch or interrupt cycles have no effect.
- R9: `flag_o` takes the value of `flag_i` at the end of phase 6 of each execute cycle and holds it at all other times.
- R10: While `clear_i` is 1, both strobes are high and both pulses low in the same clock. From the next clock the phase is 0 and the code is fetch. After release, a fetch begins at phase 0.
- R11: While `wait_i` is 1 (and clear is 0), the phase, the cycle type and every output keep their values.
- R12: While `rst_ni` is low, the outputs show phase 0, fetch, upper byte selected, strobes high, no pulses and `flag_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous restart, active high |
| wait_i | input | 1 | Freeze sequence, active high |
| dma_req_i | input | 1 | Direct memory transfer request |
| int_req_i | input | 1 | Interrupt request |
| flag_i | input | 4 | External flag lines |
| rd_req_i | input | 1 | Decode: memory read in this cycle |
| wr_req_i | input | 1 | Decode: memory write in this cycle |
| long_i | input | 1 | Decode: instruction needs two execute cycles |
| phase_o | output | 3 | Phase within the machine cycle |
| tpa_o | output | 1 | Early timing pulse, upper address byte latch |
| tpb_o | output | 1 | Late timing pulse, read data latch |
| addr_hi_o | output | 1 | 1 selects the upper address byte |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| state_code_o | output | 2 | Machine cycle type |
| flag_o | output | 4 | Flag lines captured in execute |

## Verification
A phase counter that slips moves both pulses and the byte select in the clock where it slips, so per-clock comparison of each pin catches it at once. A wrong cycle type at a boundary shows on the code in the first clock of the next cycle, and the strobes of that cycle disagree from phase 2. A request sample that is lost or stale shows one full cycle later, as a missing or extra transfer or interrupt cycle. For that reason the sequences chain execute, transfer and interrupt cycles, with competing requests held across several cycles.

// File: rtl/mc_seq_pkg.sv
package mc_seq_pkg;
  typedef enum logic [1:0] {
    ST_FETCH = 2'b00,
    ST_EXEC  = 2'b01,
    ST_DMA   = 2'b10,
    ST_INTR  = 2'b11
  } mcyc_e;
endpackage

// File: rtl/mc_phase_ctr.sv
module mc_phase_ctr #(
  parameter int PHASES = 8,
  localparam int PH_W  = $clog2(PHASES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            hold_i,
  output logic [PH_W-1:0] phase_o,
  output logic            last_o
);
  logic [PH_W-1:0] ph_q;

  assign last_o  = (ph_q == PH_W'(PHASES - 1));
  assign phase_o = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_q <= '0;
    else if (clear_i) ph_q <= '0;
    else if (!hold_i) ph_q <= last_o ? '0 : ph_q + 1'b1;
  end
endmodule

// File: rtl/mc_cycle_ctl.sv
module mc_cycle_ctl import mc_seq_pkg::*; #(
  parameter int PH_W    = 3,
  parameter int SMP_PH  = 6,
  parameter int N_FLAGS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               hold_i,
  input  logic [PH_W-1:0]    phase_i,
  input  logic               last_i,
  input  logic               dma_req_i,
  input  logic               int_req_i,
  input  logic               long_i,
  input  logic               rd_req_i,
  input  logic               wr_req_i,
  input  logic [N_FLAGS-1:0] flag_i,
  output mcyc_e              state_o,
  output logic               rd_acc_o,
  output logic               wr_acc_o,
  output logic [N_FLAGS-1:0] flag_o
);
  mcyc_e state_q, state_d;
  logic  ext_q, ext_d;
  logic  dma_q, int_q;
  logic  step, smp_pt, mem_cyc, boundary;

  assign step     = !clear_i && !hold_i;
  assign smp_pt   = step && (phase_i == PH_W'(SMP_PH));
  assign mem_cyc  = (state_q == ST_EXEC) || (state_q == ST_DMA);
  assign boundary = step && last_i;

  always_comb begin
    state_d = state_q;
    ext_d   = 1'b0;
    unique case (state_q)
      ST_FETCH: state_d = ST_EXEC;
      ST_EXEC: begin
        if (!ext_q && long_i) begin
          state_d = ST_EXEC;
          ext_d   = 1'b1;
        end else if (dma_q) state_d = ST_DMA;
        else if (int_q)     state_d = ST_INTR;
        else                state_d = ST_FETCH;
      end
      ST_DMA: begin
        if (dma_q)      state_d = ST_DMA;
        else if (int_q) state_d = ST_INTR;
        else            state_d = ST_FETCH;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      ext_q   <= 1'b0;
    end else if (clear_i) begin
      state_q <= ST_FETCH;
      ext_q   <= 1'b0;
    end else if (boundary) begin
      state_q <= state_d;
      ext_q   <= ext_d;
    end
  end

  // requests are only looked at in execute and transfer cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_q <= 1'b0;
      int_q <= 1'b0;
    end else if (clear_i) begin
      dma_q <= 1'b0;
      int_q <= 1'b0;
    end else if (smp_pt && mem_cyc) begin
      dma_q <= dma_req_i;
      int_q <= int_req_i;
    end
  end

  // access type fixed once per cycle, at the end of phase 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_acc_o <= 1'b0;
      wr_acc_o <= 1'b0;
    end else if (clear_i) begin
      rd_acc_o <= 1'b0;
      wr_acc_o <= 1'b0;
    end else if (step && phase_i == '0) begin
      rd_acc_o <= (state_q == ST_FETCH) || (mem_cyc && rd_req_i && !wr_req_i);
      wr_acc_o <= mem_cyc && wr_req_i;
    end
  end

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              flag_o[i] <= 1'b0;
      else if (smp_pt && state_q == ST_EXEC)    flag_o[i] <= flag_i[i];
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/mc_strobe_gen.sv
module mc_strobe_gen #(
  parameter int PH_W     = 3,
  parameter int TPA_PH   = 1,
  parameter int TPB_PH   = 6,
  parameter int WR_FIRST = 4,
  parameter int WR_LAST  = 5
) (
  input  logic [PH_W-1:0] phase_i,
  input  logic            clear_i,
  input  logic            rd_acc_i,
  input  logic            wr_acc_i,
  output logic            tpa_o,
  output logic            tpb_o,
  output logic            addr_hi_o,
  output logic            rd_n_o,
  output logic            wr_n_o
);
  logic in_wr_win, past_tpa;

  assign past_tpa  = phase_i > PH_W'(TPA_PH);
  assign in_wr_win = (phase_i >= PH_W'(WR_FIRST)) && (phase_i <= PH_W'(WR_LAST));

  assign tpa_o     = !clear_i && (phase_i == PH_W'(TPA_PH));
  assign tpb_o     = !clear_i && (phase_i == PH_W'(TPB_PH));
  assign addr_hi_o = !past_tpa;
  assign rd_n_o    = !(!clear_i && rd_acc_i && past_tpa);
  assign wr_n_o    = !(!clear_i && wr_acc_i && in_wr_win);
endmodule

// File: rtl/mc_seq.sv
module mc_seq import mc_seq_pkg::*; #(
  parameter int PHASES   = 8,
  parameter int TPA_PH   = 1,
  parameter int TPB_PH   = 6,
  parameter int WR_FIRST = 4,
  parameter int WR_LAST  = 5,
  parameter int N_FLAGS  = 4,
  localparam int PH_W    = $clog2(PHASES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               wait_i,
  input  logic               dma_req_i,
  input  logic               int_req_i,
  input  logic [N_FLAGS-1:0] flag_i,
  input  logic               rd_req_i,
  input  logic               wr_req_i,
  input  logic               long_i,
  output logic [PH_W-1:0]    phase_o,
  output logic               tpa_o,
  output logic               tpb_o,
  output logic               addr_hi_o,
  output logic               rd_n_o,
  output logic               wr_n_o,
  output logic [1:0]         state_code_o,
  output logic [N_FLAGS-1:0] flag_o
);
  logic [PH_W-1:0] phase;
  logic            last, rd_acc, wr_acc;
  mcyc_e           state;

  mc_phase_ctr #(.PHASES(PHASES)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .hold_i  (wait_i),
    .phase_o (phase),
    .last_o  (last)
  );

  mc_cycle_ctl #(.PH_W(PH_W), .SMP_PH(TPB_PH), .N_FLAGS(N_FLAGS)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .hold_i    (wait_i),
    .phase_i   (phase),
    .last_i    (last),
    .dma_req_i (dma_req_i),
    .int_req_i (int_req_i),
    .long_i    (long_i),
    .rd_req_i  (rd_req_i),
    .wr_req_i  (wr_req_i),
    .flag_i    (flag_i),
    .state_o   (state),
    .rd_acc_o  (rd_acc),
    .wr_acc_o  (wr_acc),
    .flag_o    (flag_o)
  );

  mc_strobe_gen #(
    .PH_W(PH_W), .TPA_PH(TPA_PH), .TPB_PH(TPB_PH),
    .WR_FIRST(WR_FIRST), .WR_LAST(WR_LAST)
  ) u_strobe (
    .phase_i   (phase),
    .clear_i   (clear_i),
    .rd_acc_i  (rd_acc),
    .wr_acc_i  (wr_acc),
    .tpa_o     (tpa_o),
    .tpb_o     (tpb_o),
    .addr_hi_o (addr_hi_o),
    .rd_n_o    (rd_n_o),
    .wr_n_o    (wr_n_o)
  );

  assign phase_o      = phase;
  assign state_code_o = state;
endmodule

// File: rtl/mc_seq_chk.sv
module mc_seq_chk #(
  parameter int PHASES = 8,
  localparam int PH_W  = $clog2(PHASES)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            clear_i,
  input logic            wait_i,
  input logic [PH_W-1:0] phase_o,
  input logic            tpa_o,
  input logic            tpb_o,
  input logic            addr_hi_o,
  input logic            rd_n_o,
  input logic            wr_n_o,
  input logic [1:0]      state_code_o
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

  AST_PHASE_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wait_i && !clear_i |=> phase_o == (($past(phase_o) == LAST_PH) ? '0 : $past(phase_o) + 1'b1)); // R1
  AST_TPA_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tpa_o && !wait_i |=> !tpa_o); // R2
  AST_TPB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tpb_o && !wait_i |=> !tpb_o); // R2
  AST_LOW_BYTE_AFTER_TPA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tpa_o && !wait_i && !clear_i |=> !addr_hi_o); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o)); // R4
  AST_INT_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_code_o == 2'b11 |-> rd_n_o && wr_n_o); // R4
  AST_WR_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_o |-> !addr_hi_o && !tpa_o && !tpb_o); // R5
  AST_FETCH_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_code_o == 2'b00 |-> wr_n_o); // R5
  AST_CODE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_code_o != $past(state_code_o) |-> phase_o == '0); // R6
  AST_INT_THEN_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_code_o == 2'b11 && phase_o == LAST_PH && !wait_i && !clear_i |=> state_code_o == 2'b00); // R6
  AST_FETCH_THEN_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_code_o == 2'b00 && phase_o == LAST_PH && !wait_i && !clear_i |=> state_code_o == 2'b01); // R6
  AST_CLEAR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |-> rd_n_o && wr_n_o && !tpa_o && !tpb_o); // R10
  AST_WAIT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_i && !clear_i |=> $stable(phase_o) && $stable(state_code_o)); // R11
endmodule

bind mc_seq mc_seq_chk #(.PHASES(PHASES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clear_i      (clear_i),
  .wait_i       (wait_i),
  .phase_o      (phase_o),
  .tpa_o        (tpa_o),
  .tpb_o        (tpb_o),
  .addr_hi_o    (addr_hi_o),
  .rd_n_o       (rd_n_o),
  .wr_n_o       (wr_n_o),
  .state_code_o (state_code_o)
);

// File: tb/tb_mc_seq.sv
module tb_mc_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clear_i = 1'b0, wait_i = 1'b0;
  logic       dma_req_i = 1'b0, int_req_i = 1'b0;
  logic [3:0] flag_i = '0;
  logic       rd_req_i = 1'b0, wr_req_i = 1'b0, long_i = 1'b0;
  logic [2:0] phase_o;
  logic       tpa_o, tpb_o, addr_hi_o, rd_n_o, wr_n_o;
  logic [1:0] state_code_o;
  logic [3:0] flag_o;

  mc_seq dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct packed {
    logic [1:0] code;
    logic [2:0] ph;
    logic       tpa, tpb, hi, rd_n, wr_n;
    logic [3:0] fl;
  } exp_t;

  exp_t       exp_q[$];
  string      tag_q[$];
  int         n_chk = 0, n_fail = 0;
  logic [3:0] exp_fl = '0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: called at a negedge showing phase 0, queues one machine cycle
  task automatic mcyc(input string st_tag, input logic [1:0] st, input bit rd, input bit wr,
                      input bit dma, input bit irq, input bit lng, input logic [3:0] fl);
    exp_t e;
    bit   ra, wa;
    rd_req_i = rd; wr_req_i = wr; dma_req_i = dma; int_req_i = irq; long_i = lng; flag_i = fl;
    ra = (st == 2'b00) || ((st == 2'b01 || st == 2'b10) && rd && !wr);
    wa = (st == 2'b01 || st == 2'b10) && wr;
    for (int p = 0; p < 8; p++) begin
      e.code = st;
      e.ph   = 3'(p);
      e.tpa  = (p == 1);
      e.tpb  = (p == 6);
      e.hi   = (p < 2);
      e.rd_n = !(ra && p >= 2);
      e.wr_n = !(wa && (p == 4 || p == 5));
      if (st == 2'b01 && p == 7) exp_fl = fl;
      e.fl   = exp_fl;
      exp_q.push_back(e);
      tag_q.push_back(st_tag);
    end
    repeat (8) @(negedge clk_i);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check("R1 phase", phase_o, e.ph);
        check("R2 tpa", tpa_o, e.tpa);
        check("R2 tpb", tpb_o, e.tpb);
        check("R3 addr_hi", addr_hi_o, e.hi);
        check("R4 rd_n", rd_n_o, e.rd_n);
        check("R5 wr_n", wr_n_o, e.wr_n);
        check({t, " state"}, state_code_o, e.code);
        check("R9 flags", flag_o, e.fl);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    // R12 reset state
    @(negedge clk_i);
    #1;
    check("R12 phase", phase_o, 0);
    check("R12 state", state_code_o, 0);
    check("R12 addr_hi", addr_hi_o, 1);
    check("R12 rd_n", rd_n_o, 1);
    check("R12 wr_n", wr_n_o, 1);
    check("R12 pulses", {tpa_o, tpb_o}, 0);
    check("R12 flags", flag_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // normal instruction, read execute
    mcyc("R6", 2'b00, 0, 0, 0, 0, 0, 4'h0);
    mcyc("R6", 2'b01, 1, 0, 0, 0, 0, 4'h5);
    // fetch ignores requests and flags; write wins over read
    mcyc("R8", 2'b00, 0, 1, 1, 1, 0, 4'hA);
    mcyc("R6", 2'b01, 1, 1, 0, 0, 0, 4'h9);
    // long instruction: two executes, never three
    mcyc("R6", 2'b00, 0, 0, 0, 0, 1, 4'h0);
    mcyc("R7", 2'b01, 0, 0, 0, 0, 1, 4'h3);
    mcyc("R7", 2'b01, 1, 0, 0, 0, 1, 4'hC);
    // transfer over interrupt, repeated transfer, then interrupt
    mcyc("R7", 2'b00, 0, 0, 0, 0, 0, 4'h0);
    mcyc("R6", 2'b01, 0, 0, 1, 1, 0, 4'h6);
    mcyc("R8", 2'b10, 1, 0, 1, 1, 0, 4'hF);
    mcyc("R8", 2'b10, 0, 1, 0, 1, 0, 4'h1);
    mcyc("R8", 2'b11, 1, 1, 1, 0, 0, 4'h2);
    // interrupt alone
    mcyc("R6", 2'b00, 0, 0, 0, 0, 0, 4'h0);
    mcyc("R6", 2'b01, 0, 0, 0, 1, 0, 4'h8);
    mcyc("R8", 2'b11, 0, 0, 0, 0, 0, 4'h0);
    // long instruction with transfer pending in its first execute
    mcyc("R6", 2'b00, 0, 0, 0, 0, 0, 4'h0);
    mcyc("R7", 2'b01, 0, 0, 1, 0, 1, 4'h4);
    mcyc("R7", 2'b01, 0, 0, 1, 0, 0, 4'h7);
    mcyc("R8", 2'b10, 0, 0, 0, 0, 0, 4'h0);
    rd_req_i = 0; wr_req_i = 0; dma_req_i = 0; int_req_i = 0; long_i = 0;

    // R11 wait: now at phase 0 of a fetch
    repeat (3) @(negedge clk_i);
    wait_i = 1'b1;
    repeat (4) @(negedge clk_i);
    #1;
    check("R11 phase held", phase_o, 3);
    check("R11 state held", state_code_o, 0);
    check("R11 rd_n held", rd_n_o, 0);
    check("R11 addr_hi held", addr_hi_o, 0);
    wait_i = 1'b0;
    @(negedge clk_i);
    #1;
    check("R11 resume phase", phase_o, 4);

    // R10 clear mid-cycle
    clear_i = 1'b1;
    dma_req_i = 1'b1;
    #1;
    check("R10 rd_n at once", rd_n_o, 1);
    check("R10 pulses", {tpa_o, tpb_o}, 0);
    @(negedge clk_i);
    #1;
    check("R10 phase", phase_o, 0);
    check("R10 state", state_code_o, 0);
    repeat (3) @(negedge clk_i);
    clear_i = 1'b0;
    dma_req_i = 1'b0;
    #1;
    check("R10 release phase", phase_o, 0);
    check("R10 release state", state_code_o, 0);
    @(negedge clk_i);
    #1;
    check("R10 fetch resumes", phase_o, 1);
    check("R10 tpa after release", tpa_o, 1);
    check("R10 fetch code", state_code_o, 0);
    repeat (2) @(negedge clk_i);
    #1;
    check("R10 fetch reads", rd_n_o, 0);
    finish_run();
  end
endmodule